// File: doc/BRIEF.md
# Multi-Link Transmit SYNC Combiner

This block serves the transmit end of a serial converter link in which one logic device feeds several converter devices. Each converter returns its own active-low SYNC request line. The block passes every line through a synchronizer into the link clock domain. It then hides the links that software has switched off and merges the remaining requests into one combined request.

The combined request drives a three-phase transmit sequencer. The phases are code group synchronization, initial lane alignment and data. The sequencer leaves code group synchronization only when no enabled link is requesting, and then only on a multiframe boundary. The boundary is supplied by the `mf_tick` strobe.

A small register port gives access to three things:
- the per-link disable mask, which can be written and read back;
- the raw synchronized SYNC levels of every link, ignoring the mask;
- the number of links fixed at build time.

There is no data stream through the block. All pins are plain control and status signals, so no valid/ready handshake applies.

Top module: `mlink_sync_tx`

## Requirements
- R1: Each `sync_n` bit reaches the status register after exactly two rising clock edges.
- R2: A read at word address 0x088 returns the synchronized SYNC levels of all links, with link i in bit i, regardless of the disable mask.
- R3: The disable mask is written and read at word address 0x086, with bit i set meaning link i is disabled. It resets to all zeros.
- R4: A disabled link never contributes to the combined request, whatever its pin level.
- R5: `req_any` is high one cycle after any enabled link's synchronized level is low. It is low one cycle after no enabled link's level is low.
- R6: With every link disabled, `req_any` stays low.
- R7: While `req_any` is high, `phase` is code group synchronization (encoding 0) on the following cycle. Reset also leaves `phase` at 0.
- R8: In code group synchronization, a cycle with `req_any` low and `mf_tick` high moves `phase` to initial lane alignment (encoding 1) on the next cycle. Encoding 3 never appears.
- R9: Initial lane alignment lasts for ILA_MFRAMES (default 4) `mf_tick` strobes with `req_any` low. The last of these strobes moves `phase` to data (encoding 2).
- R10: `req_any` high during alignment or data returns `phase` to 0 on the next cycle.
- R11: A read at word address 0x004 returns NUM_LINKS.
- R12: A read at any other address returns zero.

## Ports
| Port | Direction | Width | Description |
|---|---|---|---|
| clk | input | 1 | Link clock |
| rst_n | input | 1 | Active-low synchronous reset |
| sync_n | input | NUM_LINKS | Asynchronous active-low SYNC request per link |
| mf_tick | input | 1 | One-cycle multiframe boundary strobe |
| reg_wr | input | 1 | Register write strobe |
| reg_addr | input | 12 | Register word address |
| reg_wdata | input | NUM_LINKS | Register write data |
| reg_rdata | output | NUM_LINKS | Register read data, combinational from `reg_addr` |
| req_any | output | 1 | Combined active-high request |
| phase | output | 2 | Sequencer phase: 0 sync, 1 alignment, 2 data |

## Verification
The hardest situation to reach is the data phase followed by a re-request. Getting there needs every enabled link to stay quiet for four multiframes. A disabled link that is held low must also stay invisible throughout.

The stimulus moves each link toward a target level on its own randomly chosen cycle, so lines change on different edges from one another. The target is all-quiet for long stretches, and masks are rewritten from time to time. Directed sequences first drive a masked link low while the sequencer reaches data. They then drop an enabled link low to force the return.

// File: rtl/mls_pkg.sv
package mls_pkg;
  localparam int ADDR_W = 12;

  typedef enum logic [1:0] {
    PH_CGS  = 2'd0,
    PH_ILA  = 2'd1,
    PH_DATA = 2'd2
  } mls_phase_e;

  localparam logic [ADDR_W-1:0] ADR_COUNT   = 12'h004;
  localparam logic [ADDR_W-1:0] ADR_DISABLE = 12'h086;
  localparam logic [ADDR_W-1:0] ADR_RAW     = 12'h088;
endpackage

// File: rtl/mls_sync_bank.sv
module mls_sync_bank #(
  parameter int N      = 4,
  parameter int STAGES = 2
) (
  input  logic         clk,
  input  logic         rst_n,
  input  logic [N-1:0] pin_n,
  output logic [N-1:0] level_n
);
  genvar g;
  generate
    for (g = 0; g < N; g++) begin : g_link
      logic [STAGES-1:0] chain;
      always_ff @(posedge clk) begin
        if (!rst_n) chain <= '1;
        else        chain <= {chain[STAGES-2:0], pin_n[g]};
      end
      assign level_n[g] = chain[STAGES-1];
    end
  endgenerate
endmodule

// File: rtl/mls_combiner.sv
module mls_combiner #(
  parameter int N = 4
) (
  input  logic         clk,
  input  logic         rst_n,
  input  logic [N-1:0] level_n,
  input  logic [N-1:0] off_mask,
  output logic         req
);
  logic [N-1:0] live;

  always_comb live = ~level_n & ~off_mask;

  always_ff @(posedge clk) begin
    if (!rst_n) req <= 1'b0;
    else        req <= |live;
  end
endmodule

// File: rtl/mls_phase_fsm.sv
module mls_phase_fsm
  import mls_pkg::*;
#(
  parameter int ILA_MFRAMES = 4
) (
  input  logic       clk,
  input  logic       rst_n,
  input  logic       req,
  input  logic       mf_tick,
  output mls_phase_e phase
);
  localparam int CNT_W = $clog2(ILA_MFRAMES + 1);
  localparam logic [CNT_W-1:0] LAST = CNT_W'(ILA_MFRAMES - 1);

  mls_phase_e       st_q, st_d;
  logic [CNT_W-1:0] cnt_q, cnt_d;

  always_comb begin
    st_d  = st_q;
    cnt_d = cnt_q;
    unique case (st_q)
      PH_CGS: begin
        if (!req && mf_tick) begin
          st_d  = PH_ILA;
          cnt_d = '0;
        end
      end
      PH_ILA: begin
        if (req) begin
          st_d = PH_CGS;
        end else if (mf_tick) begin
          if (cnt_q == LAST) st_d = PH_DATA;
          else               cnt_d = cnt_q + 1'b1;
        end
      end
      PH_DATA: begin
        if (req) st_d = PH_CGS;
      end
      default: st_d = PH_CGS;
    endcase
  end

  always_ff @(posedge clk) begin
    if (!rst_n) begin
      st_q  <= PH_CGS;
      cnt_q <= '0;
    end else begin
      st_q  <= st_d;
      cnt_q <= cnt_d;
    end
  end

  assign phase = st_q;
endmodule

// File: rtl/mls_regs.sv
module mls_regs
  import mls_pkg::*;
#(
  parameter int N = 4
) (
  input  logic              clk,
  input  logic              rst_n,
  input  logic              wr,
  input  logic [ADDR_W-1:0] addr,
  input  logic [N-1:0]      wdata,
  input  logic [N-1:0]      raw_level,
  output logic [N-1:0]      off_mask,
  output logic [N-1:0]      rdata
);
  always_ff @(posedge clk) begin
    if (!rst_n)                          off_mask <= '0;
    else if (wr && addr == ADR_DISABLE)  off_mask <= wdata;
  end

  always_comb begin
    unique case (addr)
      ADR_DISABLE: rdata = off_mask;
      ADR_RAW:     rdata = raw_level;
      ADR_COUNT:   rdata = N[N-1:0];
      default:     rdata = '0;
    endcase
  end
endmodule

// File: rtl/mlink_sync_tx.sv
module mlink_sync_tx
  import mls_pkg::*;
#(
  parameter int NUM_LINKS   = 4,
  parameter int SYNC_STAGES = 2,
  parameter int ILA_MFRAMES = 4
) (
  input  logic                 clk,
  input  logic                 rst_n,
  input  logic [NUM_LINKS-1:0] sync_n,
  input  logic                 mf_tick,
  input  logic                 reg_wr,
  input  logic [11:0]          reg_addr,
  input  logic [NUM_LINKS-1:0] reg_wdata,
  output logic [NUM_LINKS-1:0] reg_rdata,
  output logic                 req_any,
  output logic [1:0]           phase
);
  logic [NUM_LINKS-1:0] raw_level;
  logic [NUM_LINKS-1:0] dis_mask;
  mls_phase_e           ph;

  mls_sync_bank #(.N(NUM_LINKS), .STAGES(SYNC_STAGES)) u_sync (
    .clk(clk), .rst_n(rst_n), .pin_n(sync_n), .level_n(raw_level)
  );

  mls_regs #(.N(NUM_LINKS)) u_regs (
    .clk(clk), .rst_n(rst_n), .wr(reg_wr), .addr(reg_addr),
    .wdata(reg_wdata), .raw_level(raw_level), .off_mask(dis_mask),
    .rdata(reg_rdata)
  );

  mls_combiner #(.N(NUM_LINKS)) u_comb (
    .clk(clk), .rst_n(rst_n), .level_n(raw_level), .off_mask(dis_mask),
    .req(req_any)
  );

  mls_phase_fsm #(.ILA_MFRAMES(ILA_MFRAMES)) u_fsm (
    .clk(clk), .rst_n(rst_n), .req(req_any), .mf_tick(mf_tick), .phase(ph)
  );

  assign phase = ph;
endmodule

// File: rtl/mls_checker.sv
module mls_checker #(
  parameter int N = 4
) (
  input logic         clk,
  input logic         rst_n,
  input logic [N-1:0] dis_mask,
  input logic [N-1:0] raw_level,
  input logic         req,
  input logic         mf_tick,
  input logic [1:0]   phase
);
  p_all_off_r6: assert property (@(posedge clk) disable iff (!rst_n)
    (&dis_mask) |=> !req);

  p_masked_quiet_r4: assert property (@(posedge clk) disable iff (!rst_n)
    ((raw_level | dis_mask) == '1) |=> !req);

  p_enabled_low_r5: assert property (@(posedge clk) disable iff (!rst_n)
    ((~raw_level & ~dis_mask) != '0) |=> req);

  p_hold_cgs_r7: assert property (@(posedge clk) disable iff (!rst_n)
    req |=> (phase == 2'd0));

  p_enter_ila_r8: assert property (@(posedge clk) disable iff (!rst_n)
    (phase == 2'd0 && !req && mf_tick) |=> (phase == 2'd1));

  p_legal_code_r8: assert property (@(posedge clk) disable iff (!rst_n)
    phase != 2'd3);

  p_no_skip_r9: assert property (@(posedge clk) disable iff (!rst_n)
    (phase == 2'd0) |=> (phase != 2'd2));

  p_fall_back_r10: assert property (@(posedge clk) disable iff (!rst_n)
    (phase != 2'd0 && req) |=> (phase == 2'd0));
endmodule

bind mlink_sync_tx mls_checker #(.N(NUM_LINKS)) u_chk (
  .clk(clk), .rst_n(rst_n), .dis_mask(dis_mask), .raw_level(raw_level),
  .req(req_any), .mf_tick(mf_tick), .phase(phase)
);

// File: tb/mlink_sync_tx_tb.sv
module mlink_sync_tx_tb;
  localparam int CLK_PERIOD = 10;
  localparam int N   = 4;
  localparam int ILA = 4;

  logic         clk = 1'b0;
  logic         rst_n = 1'b0;
  logic [N-1:0] sync_n = '1;
  logic         mf_tick = 1'b0;
  logic         reg_wr = 1'b0;
  logic [11:0]  reg_addr = '0;
  logic [N-1:0] reg_wdata = '0;
  logic [N-1:0] reg_rdata;
  logic         req_any;
  logic [1:0]   phase;

  int checks = 0;
  int fails  = 0;

  mlink_sync_tx #(.NUM_LINKS(N), .SYNC_STAGES(2), .ILA_MFRAMES(ILA)) u_dut (
    .clk(clk), .rst_n(rst_n), .sync_n(sync_n), .mf_tick(mf_tick),
    .reg_wr(reg_wr), .reg_addr(reg_addr), .reg_wdata(reg_wdata),
    .reg_rdata(reg_rdata), .req_any(req_any), .phase(phase)
  );

  always #(CLK_PERIOD/2) clk = ~clk;

  // reference model built from the requirements
  logic [N-1:0] m_s1, m_s2, m_mask;
  logic         m_req;
  logic [1:0]   m_ph;
  int           m_cnt;

  always @(posedge clk) begin
    if (!rst_n) begin
      m_s1 <= '1; m_s2 <= '1; m_mask <= '0; m_req <= 1'b0;
      m_ph <= 2'd0; m_cnt <= 0;
    end else begin
      m_s1 <= sync_n;
      m_s2 <= m_s1;
      if (reg_wr && reg_addr == 12'h086) m_mask <= reg_wdata;
      m_req <= |(~m_s2 & ~m_mask);
      case (m_ph)
        2'd0: if (!m_req && mf_tick) begin m_ph <= 2'd1; m_cnt <= 0; end
        2'd1: if (m_req) m_ph <= 2'd0;
              else if (mf_tick) begin
                if (m_cnt == ILA-1) m_ph <= 2'd2; else m_cnt <= m_cnt + 1;
              end
        default: if (m_req) m_ph <= 2'd0;
      endcase
    end
  end

  function automatic logic [N-1:0] exp_read(input logic [11:0] a);
    case (a)
      12'h086: return m_mask;
      12'h088: return m_s2;
      12'h004: return N[N-1:0];
      default: return '0;
    endcase
  endfunction

  task automatic check(input string tag, input int got, input int exp);
    checks++;
    if (got !== exp) begin
      fails++;
      $display("FAIL %s: got %0d expected %0d at %0t", tag, got, exp, $time);
    end
  endtask

  task automatic read_chk(input string tag, input logic [11:0] a);
    reg_addr = a;
    #1;
    check(tag, int'(reg_rdata), int'(exp_read(a)));
  endtask

  // one clock, then compare outputs with the model away from the edge
  task automatic step();
    @(posedge clk);
    @(negedge clk);
    reg_wr  = 1'b0;
    mf_tick = 1'b0;
    check("R5", int'(req_any), int'(m_req));
    check("R7", int'(phase), int'(m_ph));
  endtask

  task automatic write_mask(input logic [N-1:0] v);
    reg_wr = 1'b1; reg_addr = 12'h086; reg_wdata = v;
    step();
  endtask

  function automatic void summary();
    $display("End of test - %0d assertions evaluated, %0d failures", checks, fails);
  endfunction

  initial begin
    #(CLK_PERIOD * 150000);
    fails++;
    $display("FAIL watchdog: got timeout expected completion");
    summary();
    $finish;
  end

  initial begin
    logic [N-1:0] target;
    int seg;
    void'($urandom(32'd20240607));
    repeat (3) @(negedge clk);
    rst_n = 1'b1;
    // reset state
    check("R7", int'(phase), 0);
    check("R5", int'(req_any), 0);
    read_chk("R3", 12'h086);
    read_chk("R11", 12'h004);
    check("R11", int'(reg_rdata), N);
    read_chk("R12", 12'h123);
    check("R12", int'(reg_rdata), 0);

    // R1: two-edge synchronizer latency seen in status
    sync_n = 4'b0101;
    step();
    read_chk("R1", 12'h088);
    check("R1", int'(reg_rdata), 4'hF);
    step();
    read_chk("R2", 12'h088);
    check("R1", int'(reg_rdata), 4'b0101);
    step();
    check("R5", int'(req_any), 1);

    // R6: all links disabled with all pins low
    sync_n = 4'b0000;
    write_mask(4'hF);
    read_chk("R3", 12'h086);
    check("R3", int'(reg_rdata), 4'hF);
    repeat (3) step();
    check("R6", int'(req_any), 0);
    read_chk("R2", 12'h088);
    check("R2", int'(reg_rdata), 0);

    // R4: link 0 low but disabled, others quiet; reach data phase
    sync_n = 4'b1110;
    write_mask(4'b0001);
    repeat (3) step();
    check("R4", int'(req_any), 0);
    mf_tick = 1'b1;
    step();
    check("R8", int'(phase), 1);
    for (int k = 0; k < ILA - 1; k++) begin
      mf_tick = 1'b1;
      step();
      check("R9", int'(phase), 1);
    end
    mf_tick = 1'b1;
    step();
    check("R9", int'(phase), 2);

    // R10: enabled link 2 asks again during data
    sync_n = 4'b1010;
    step(); step();
    check("R10", int'(req_any), 0);
    step();
    check("R10", int'(req_any), 1);
    check("R10", int'(phase), 2);
    step();
    check("R10", int'(phase), 0);

    // random phase: links drift toward targets on independent cycles
    target = '1;
    seg = 0;
    for (int cyc = 0; cyc < 6000; cyc++) begin
      if (seg == 0) begin
        seg = 20 + int'($urandom_range(0, 200));
        target = ($urandom_range(0, 2) == 0) ? N'($urandom) : '1;
      end
      seg--;
      for (int i = 0; i < N; i++)
        if ($urandom_range(0, 7) == 0) sync_n[i] = target[i];
      mf_tick = ($urandom_range(0, 5) == 0);
      if ($urandom_range(0, 150) == 0) begin
        reg_wr = 1'b1; reg_addr = 12'h086;
        reg_wdata = ($urandom_range(0, 3) == 0) ? '1 : N'($urandom_range(0, 3));
      end else begin
        reg_addr = ($urandom_range(0, 1) == 0) ? 12'h088 : 12'h086;
      end
      step();
      if (cyc % 16 == 0) read_chk("R2", 12'h088);
      if (cyc % 16 == 8) read_chk("R3", 12'h086);
    end

    summary();
    $finish;
  end
endmodule